// File: doc/BRIEF.md
# Serial Control Word Loader

This block takes synthesizer configuration from a three-wire serial port (serial clock, serial data and load strobe) and turns it into parallel register values. Bits enter a shift register on each rising edge of the serial clock, most significant bit first. When the load strobe rises, the last bit shifted in chooses which of two holding groups receives the rest of the word.

The reference group holds a 14-bit reference division ratio and three single-bit flags: prescaler modulus select, phase polarity and monitor output select. The counter group holds a 7-bit swallow count and an 11-bit main counter ratio. A reference or main ratio below 3 is not allowed. Such a word is still stored, but it raises an error flag. All three serial lines are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain.

Top module: `scw_loader`

## Requirements
- R1: Each rising edge of `ser_clk` seen while `ser_le` is low shifts `ser_data` into the shift register, most significant bit first. The bit shifted in last (position 0) is the control bit.
- R2: On a load whose control bit is 1, the reference group is written. Positions are counted back from the last bit shifted in. Positions 1 to 14 give `ref_ratio`, with position 1 as its LSB. Position 15 gives `presc_sel`, position 16 gives `phase_pol` and position 17 gives `out_sel`.
- R3: On a load whose control bit is 0, the counter group is written. Positions 1 to 7 give `swallow`, with position 1 as its LSB. Positions 8 to 18 give `main_ratio`, with position 8 as its LSB.
- R4: A load takes place only on a rising edge of `ser_le`. The group not selected by the control bit keeps its value.
- R5: Rising edges of `ser_clk` that arrive while `ser_le` is high do not change the shift register.
- R6: The bit count is not checked. Only the 19 most recently shifted bits take part in a load, and earlier bits are discarded.
- R7: A load that writes a reference ratio below 3, or a main ratio below 3, still stores that value and sets `ratio_err`.
- R8: `ratio_err` stays set until the next load whose written ratio is 3 or more, which clears it.
- R9: After reset all holding outputs, `ref_loaded`, `cnt_loaded` and `ratio_err` are 0. `ref_loaded` and `cnt_loaded` go to 1 on the first load of their own group and then stay at 1.
- R10: The outputs show a load no later than the fourth rising edge of `clk` after `ser_le` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a rising edge commits the word |
| ref_ratio | output | 14 | Reference division ratio |
| presc_sel | output | 1 | Prescaler modulus select flag |
| phase_pol | output | 1 | Phase comparator polarity flag |
| out_sel | output | 1 | Monitor output select flag |
| swallow | output | 7 | Swallow counter value |
| main_ratio | output | 11 | Main counter ratio |
| ref_loaded | output | 1 | Reference group written at least once |
| cnt_loaded | output | 1 | Counter group written at least once |
| ratio_err | output | 1 | Last load wrote a ratio below 3 |

## Verification
The assertions assume that each serial line holds every level for at least three system clock cycles. They also assume that `ser_data` is steady around the rising edge of `ser_clk`. If both hold, every edge is seen exactly once, and the data bit is aligned with the synchronized clock edge. The bench meets this by holding each phase of a serial bit for four system clocks, and by keeping the load strobe high for eight. Within that timing it varies the word contents, the control bit, the ratio values near the limit of 3, the number of bits sent, and clock activity while the strobe is high.

// File: rtl/scw_pkg.sv
package scw_pkg;
    localparam int REF_W    = 14;
    localparam int SWL_W    = 7;
    localparam int MAIN_W   = 11;
    localparam int WORD_W   = 1 + SWL_W + MAIN_W;
    localparam int RATIO_MIN = 3;

    localparam int REF_LSB  = 1;
    localparam int PRE_POS  = REF_LSB + REF_W;
    localparam int POL_POS  = PRE_POS + 1;
    localparam int OSEL_POS = POL_POS + 1;
    localparam int SWL_LSB  = 1;
    localparam int MAIN_LSB = SWL_LSB + SWL_W;

    typedef struct packed {
        logic [REF_W-1:0] ratio;
        logic             presc;
        logic             pol;
        logic             osel;
    } ref_grp_t;

    typedef struct packed {
        logic [SWL_W-1:0]  swl;
        logic [MAIN_W-1:0] main;
    } cnt_grp_t;

    function automatic ref_grp_t unpack_ref(input logic [WORD_W-1:0] w);
        ref_grp_t g;
        g.ratio = w[REF_LSB +: REF_W];
        g.presc = w[PRE_POS];
        g.pol   = w[POL_POS];
        g.osel  = w[OSEL_POS];
        return g;
    endfunction

    function automatic cnt_grp_t unpack_cnt(input logic [WORD_W-1:0] w);
        cnt_grp_t g;
        g.swl  = w[SWL_LSB +: SWL_W];
        g.main = w[MAIN_LSB +: MAIN_W];
        return g;
    endfunction
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic ff1, ff2;
        always_ff @(posedge clk) begin
            if (rst) begin
                ff1 <= 1'b0;
                ff2 <= 1'b0;
            end else begin
                ff1 <= d[i];
                ff2 <= ff1;
            end
        end
        assign q[i] = ff2;
    end
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              le_s,
    output logic [WORD_W-1:0] word_q,
    output logic              load_pulse
);
    logic sclk_d, le_d;
    logic shift_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            le_d   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            le_d   <= le_s;
        end
    end

    assign shift_en   = sclk_s & ~sclk_d & ~le_s;
    assign load_pulse = le_s & ~le_d;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else if (shift_en)
            word_q <= {word_q[WORD_W-2:0], sdata_s};
    end
endmodule

// File: rtl/scw_latch.sv
module scw_latch
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output ref_grp_t          ref_q,
    output cnt_grp_t          cnt_q,
    output logic              ref_ld,
    output logic              cnt_ld,
    output logic              err
);
    ref_grp_t ref_n;
    cnt_grp_t cnt_n;
    logic     to_ref;
    logic     bad;

    assign to_ref = word[0];
    assign ref_n  = unpack_ref(word);
    assign cnt_n  = unpack_cnt(word);
    assign bad    = to_ref ? (ref_n.ratio < REF_W'(RATIO_MIN))
                           : (cnt_n.main  < MAIN_W'(RATIO_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            cnt_q  <= '0;
            ref_ld <= 1'b0;
            cnt_ld <= 1'b0;
            err    <= 1'b0;
        end else if (load) begin
            err <= bad;
            if (to_ref) begin
                ref_q  <= ref_n;
                ref_ld <= 1'b1;
            end else begin
                cnt_q  <= cnt_n;
                cnt_ld <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/scw_loader.sv
module scw_loader
    import scw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              phase_pol,
    output logic              out_sel,
    output logic [SWL_W-1:0]  swallow,
    output logic [MAIN_W-1:0] main_ratio,
    output logic              ref_loaded,
    output logic              cnt_loaded,
    output logic              ratio_err
);
    logic [2:0]        sync_q;
    logic [WORD_W-1:0] word_q;
    logic              load_pulse;
    ref_grp_t          ref_q;
    cnt_grp_t          cnt_q;

    scw_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_le, ser_data, ser_clk}),
        .q   (sync_q)
    );

    scw_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sync_q[0]),
        .sdata_s    (sync_q[1]),
        .le_s       (sync_q[2]),
        .word_q     (word_q),
        .load_pulse (load_pulse)
    );

    scw_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .load   (load_pulse),
        .word   (word_q),
        .ref_q  (ref_q),
        .cnt_q  (cnt_q),
        .ref_ld (ref_loaded),
        .cnt_ld (cnt_loaded),
        .err    (ratio_err)
    );

    assign ref_ratio  = ref_q.ratio;
    assign presc_sel  = ref_q.presc;
    assign phase_pol  = ref_q.pol;
    assign out_sel    = ref_q.osel;
    assign swallow    = cnt_q.swl;
    assign main_ratio = cnt_q.main;
endmodule

// File: rtl/scw_loader_chk.sv
module scw_loader_chk
    import scw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic              le_s,
    input logic [WORD_W-1:0] word_q,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              presc_sel,
    input logic              phase_pol,
    input logic              out_sel,
    input logic [SWL_W-1:0]  swallow,
    input logic [MAIN_W-1:0] main_ratio,
    input logic              ref_loaded,
    input logic              cnt_loaded,
    input logic              ratio_err
);
    // R4
    ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && word_q[0]) |=> $stable({ref_ratio, presc_sel, phase_pol, out_sel}));
    // R4
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(load && !word_q[0]) |=> $stable({swallow, main_ratio}));
    // R5
    le_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        le_s |=> $stable(word_q));
    // R9
    ref_ld_set_chk: assert property (@(posedge clk) disable iff (rst)
        (load && word_q[0]) |=> ref_loaded);
    // R9
    cnt_ld_set_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !word_q[0]) |=> cnt_loaded);
    // R9
    ld_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(ref_loaded) && !$fell(cnt_loaded));
    // R7
    ref_err_chk: assert property (@(posedge clk) disable iff (rst)
        (load && word_q[0]) |=> (ratio_err == (ref_ratio < REF_W'(RATIO_MIN))));
    // R7
    cnt_err_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !word_q[0]) |=> (ratio_err == (main_ratio < MAIN_W'(RATIO_MIN))));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ratio_err));
endmodule

bind scw_loader scw_loader_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load_pulse),
    .le_s       (sync_q[2]),
    .word_q     (word_q),
    .ref_ratio  (ref_ratio),
    .presc_sel  (presc_sel),
    .phase_pol  (phase_pol),
    .out_sel    (out_sel),
    .swallow    (swallow),
    .main_ratio (main_ratio),
    .ref_loaded (ref_loaded),
    .cnt_loaded (cnt_loaded),
    .ratio_err  (ratio_err)
);

// File: tb/tb_scw_loader.sv
module tb_scw_loader;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic presc_sel, phase_pol, out_sel;
    logic [6:0]  swallow;
    logic [10:0] main_ratio;
    logic ref_loaded, cnt_loaded, ratio_err;

    int n_chk = 0, n_bad = 0;

    logic [13:0] e_ratio = '0;
    logic e_pre = 0, e_pol = 0, e_osel = 0;
    logic [6:0]  e_swl = '0;
    logic [10:0] e_main = '0;
    logic e_rld = 0, e_cld = 0, e_err = 0;

    always #5 clk = ~clk;

    scw_loader dut (.*);

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmp(input string req, input string name, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, name, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "ref_ratio",  ref_ratio,  e_ratio);
        cmp(req, "presc_sel",  presc_sel,  e_pre);
        cmp(req, "phase_pol",  phase_pol,  e_pol);
        cmp(req, "out_sel",    out_sel,    e_osel);
        cmp(req, "swallow",    swallow,    e_swl);
        cmp(req, "main_ratio", main_ratio, e_main);
        cmp(req, "ref_loaded", ref_loaded, e_rld);
        cmp(req, "cnt_loaded", cnt_loaded, e_cld);
        cmp(req, "ratio_err",  ratio_err,  e_err);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic pulse_le();
        ser_le = 1'b1;
        wait_clk(8);
        ser_le = 1'b0;
        wait_clk(4);
    endtask

    // model of a load of the low 19 bits of w
    function automatic void model_load(input logic [18:0] w);
        if (w[0]) begin
            e_ratio = w[14:1]; e_pre = w[15]; e_pol = w[16]; e_osel = w[17];
            e_rld = 1'b1; e_err = (w[14:1] < 14'd3);
        end else begin
            e_swl = w[7:1]; e_main = w[18:8];
            e_cld = 1'b1; e_err = (w[18:8] < 11'd3);
        end
    endfunction

    function automatic logic [18:0] mk_ref(input logic [13:0] r, input logic p, input logic q, input logic o);
        return {1'b0, o, q, p, r, 1'b1};
    endfunction

    function automatic logic [18:0] mk_cnt(input logic [10:0] n, input logic [6:0] a);
        return {n, a, 1'b0};
    endfunction

    initial begin
        logic [18:0] w;
        void'($urandom(32'h5C1_0AD));
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R9 reset state
        check_all("R9");

        // R1 R2 directed reference load
        w = mk_ref(14'h2A5B, 1'b1, 1'b0, 1'b1);
        shift_bits({13'd0, w}, 18);
        pulse_le(); model_load(w);
        check_all("R2");

        // R3 R4 counter load, reference kept
        w = mk_cnt(11'd1234, 7'd77);
        shift_bits({13'd0, w}, 19);
        pulse_le(); model_load(w);
        check_all("R3");

        // R7 reference ratio 2 stored and flagged
        w = mk_ref(14'd2, 1'b0, 1'b1, 1'b0);
        shift_bits({13'd0, w}, 18);
        pulse_le(); model_load(w);
        check_all("R7");

        // R8 sticky: another bad load (main 1) keeps flag
        w = mk_cnt(11'd1, 7'd0);
        shift_bits({13'd0, w}, 19);
        pulse_le(); model_load(w);
        check_all("R8");
        // R8 wait: flag holds with no load
        wait_clk(20);
        check_all("R8");

        // R8 valid load at boundary 3 clears the flag
        w = mk_cnt(11'd3, 7'd127);
        shift_bits({13'd0, w}, 19);
        pulse_le(); model_load(w);
        check_all("R8");

        // R5 clock edges while ser_le high ignored; reload reproduces same counter word
        ser_le = 1'b1;
        wait_clk(6);
        ser_data = 1'b1;
        for (int k = 0; k < 5; k++) begin
            ser_clk = 1'b1; wait_clk(4);
            ser_clk = 1'b0; wait_clk(4);
        end
        ser_le = 1'b0;
        wait_clk(6);
        pulse_le(); model_load(w);
        check_all("R5");

        // R6 excess leading bits discarded
        w = mk_ref(14'd16383, 1'b1, 1'b1, 1'b1);
        shift_bits({7'h55, 6'h3F, w}, 25);
        pulse_le(); model_load(w);
        check_all("R6");

        // R10 latency: outputs settled four clocks after ser_le rises
        w = mk_cnt(11'd2047, 7'd5);
        shift_bits({13'd0, w}, 19);
        ser_le = 1'b1;
        @(posedge clk); @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        model_load(w);
        check_all("R10");
        wait_clk(4);
        ser_le = 1'b0;
        wait_clk(4);

        // random mix, R1 R2 R3 R7
        for (int it = 0; it < 40; it++) begin
            w = 19'($urandom());
            if (($urandom() % 4) == 0) begin
                w[14:1] = 14'($urandom() % 5);
                w[18:8] = 11'($urandom() % 5);
            end
            shift_bits({13'd0, w}, 19);
            pulse_le(); model_load(w);
            check_all(w[0] ? "R2" : "R3");
        end

        // R9 reset returns everything to zero
        rst = 1'b1; wait_clk(3); rst = 1'b0; wait_clk(2);
        e_ratio = '0; e_pre = 0; e_pol = 0; e_osel = 0; e_swl = '0; e_main = '0;
        e_rld = 0; e_cld = 0; e_err = 0;
        check_all("R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule